// File: doc/BRIEF.md
# SAR ADC Scan Sequencer

This block is the digital controller of a 10-bit successive-approximation converter that serves up to 16 analog channels. It selects a channel on an analog multiplexer and drives a trial code to an external DAC. Each clock it takes the comparator's one-bit decision and uses it to resolve one bit of the code, from the MSB down to the LSB. When the last bit is known, the code is written into that channel's result register. The analog DAC, sample-and-hold and comparator sit outside the block.

Software reaches the block through a flat register interface. Writes are single-cycle strobes and reads are combinational. There are three sequencing modes. Single mode converts one channel. One-pass scan converts channels 0 up to a programmed last channel once. Continuous scan repeats that pass until software stops it.

A compare-only mode is also available when single mode is selected. In this mode, software writes a code, the block compares the selected channel against that code once, and it stores the outcome in that channel's bit of a flag register.

Top module: `sar_scan_ctrl`

## Requirements
- R1: After reset the block is idle. The control word (address 0) reads 0: mode, compare enable, busy, done and channel are all 0. Every result register reads 0 and the flag register (address 2) reads 0.
- R2: A conversion sets each trial bit from bit 9 down to bit 0, one bit per clock. The bit is kept when `cmp_i` is 1 (input at or above the DAC level) and cleared otherwise. With DAC level 0 for code 0 and (code - 0.5) LSB for other codes, the result is the largest code whose level does not exceed the input.
- R3: The 10-bit result of channel c reads at address 16+c in bits [9:0]. Address 32+c returns bits [9:2] of that result in read bits [7:0].
- R4: Control write fields are: [1:0] mode (0 single, 1 one-pass scan, 2 continuous, 3 treated as single), [2] compare enable, [3] start, [6] stop, [11:8] channel (in scan modes, the last channel). Reads of address 0 return mode, compare enable, [4] busy, [5] done and channel. In single mode a start converts the programmed channel. Busy then holds for 11 cycles (10 bit cycles and one store cycle), after which the block is idle with done set.
- R5: In one-pass scan, channels are converted in ascending order from 0 to the last channel. The block stops after the last channel, and channels above it are left unchanged.
- R6: In continuous scan, the block wraps from the last channel back to channel 0 and keeps converting, so results follow input changes. It stops only when a control write with bit 6 set arrives.
- R7: A stop received during a conversion aborts it in the next cycle without writing the channel's result. The block goes idle with done set.
- R8: With compare enable set, single mode selected and the block idle, writing a code to address 1 starts one compare of the selected channel against that code. Done is cleared for that one compare cycle and then set again. Flag bit c of address 2 is set to 1 if the DAC level of the code exceeds the input, and to 0 otherwise. Address 1 reads back the approximation register.
- R9: A code write is ignored when compare enable is 0 or a scan mode is selected. A start, and any change to the configuration fields, is ignored while the block is busy.
- R10: `dac_code_o` shows the trial code during a conversion. In the first bit cycle it is 0x200. In each later cycle it holds the bits already resolved plus the next lower trial bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Register address for reads and writes |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Combinational read data |
| cmp_i | input | 1 | Comparator decision: 1 when the input is at or above the DAC level |
| dac_code_o | output | 10 | Code driven to the DAC |
| ch_sel_o | output | 4 | Analog multiplexer channel select |

## Verification
The embedded assertions check, on every cycle, several properties of the control path. The bits below the trial bit stay clear during a conversion. The store cycle comes after exactly ten bit cycles. Scan steps go to the next channel, and a wrap goes back to channel 0. A stop or a finished compare returns the block to idle with done set. Every result or flag write lands in the addressed register. Only the bench's scenarios can show that the converted codes match the half-LSB DAC transfer, that the scan bounds and stop points leave the right registers untouched, and that ignored starts and code writes really change nothing at the ports.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE  = 2'd0,
    MODE_ONESHOT = 2'd1,
    MODE_CONT    = 2'd2,
    MODE_RSVD    = 2'd3
  } scan_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_STORE = 2'd2,
    ST_CMP   = 2'd3
  } seq_state_e;

  localparam int unsigned ADR_CTRL = 0;
  localparam int unsigned ADR_CODE = 1;
  localparam int unsigned ADR_FLAG = 2;

  localparam int unsigned CTL_START_BIT = 3;
  localparam int unsigned CTL_STOP_BIT  = 6;
  localparam int unsigned CTL_CH_LSB    = 8;
endpackage

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
  parameter int unsigned BITS  = 10,
  localparam int unsigned IDX_W = $clog2(BITS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_trial_i,
  input  logic            load_code_i,
  input  logic [BITS-1:0] code_i,
  input  logic            step_i,
  input  logic            keep_i,
  output logic [BITS-1:0] sar_o,
  output logic            last_o
);
  logic [BITS-1:0]  sar_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sar_q <= '0;
      idx_q <= '0;
    end else if (load_trial_i) begin
      sar_q <= {1'b1, {(BITS-1){1'b0}}};
      idx_q <= IDX_W'(BITS-1);
    end else if (load_code_i) begin
      sar_q <= code_i;
      idx_q <= '0;
    end else if (step_i) begin
      sar_q[idx_q] <= keep_i;
      if (idx_q != '0) begin
        sar_q[idx_q - 1'b1] <= 1'b1;
        idx_q <= idx_q - 1'b1;
      end
    end
  end

  assign sar_o  = sar_q;
  assign last_o = (idx_q == '0);

  logic [BITS-1:0] low_mask;
  assign low_mask = ~({BITS{1'b1}} << idx_q);

  // R2: nothing below the trial bit is set while bits are being resolved
  a_r2_low_bits_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> ((sar_q & low_mask) == '0));

  // R10: trial bit moves down one position per step
  a_r10_trial_walk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && idx_q != '0 && !load_trial_i) |=> idx_q == $past(idx_q) - 1'b1);
endmodule

// File: rtl/sar_result_bank.sv
module sar_result_bank #(
  parameter int unsigned CH   = 16,
  parameter int unsigned BITS = 10,
  localparam int unsigned CH_W = $clog2(CH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            res_we_i,
  input  logic [CH_W-1:0] res_ch_i,
  input  logic [BITS-1:0] res_data_i,
  input  logic            flag_we_i,
  input  logic [CH_W-1:0] flag_ch_i,
  input  logic            flag_i,
  input  logic [CH_W-1:0] rd_ch_i,
  output logic [BITS-1:0] rd_res_o,
  output logic [CH-1:0]   flags_o
);
  logic [BITS-1:0] res_q [CH];
  logic [CH-1:0]   flags_q;

  for (genvar g = 0; g < CH; g++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        res_q[g] <= '0;
      end else if (res_we_i && res_ch_i == CH_W'(g)) begin
        res_q[g] <= res_data_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flags_q[g] <= 1'b0;
      end else if (flag_we_i && flag_ch_i == CH_W'(g)) begin
        flags_q[g] <= flag_i;
      end
    end
  end

  assign rd_res_o = res_q[rd_ch_i];
  assign flags_o  = flags_q;

  // R3: a stored result lands in the addressed channel
  a_r3_store_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_we_i |=> res_q[$past(res_ch_i)] == $past(res_data_i));

  // R8: a compare outcome lands in the addressed flag bit
  a_r8_flag_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i |=> flags_q[$past(flag_ch_i)] == $past(flag_i));
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
  import sar_pkg::*;
#(
  parameter int unsigned CH   = 16,
  parameter int unsigned BITS = 10,
  localparam int unsigned CH_W  = $clog2(CH),
  localparam int unsigned CNT_W = $clog2(BITS + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            stop_i,
  input  logic            code_wr_i,
  input  logic            is_single_i,
  input  logic            is_oneshot_i,
  input  logic            cmp_en_i,
  input  logic [CH_W-1:0] chan_i,
  input  logic            last_bit_i,
  output logic            load_trial_o,
  output logic            load_code_o,
  output logic            step_o,
  output logic            res_we_o,
  output logic            flag_we_o,
  output logic [CH_W-1:0] ch_o,
  output logic            busy_o,
  output logic            done_o
);
  seq_state_e      state_q, state_d;
  logic [CH_W-1:0] ch_q, ch_d;
  logic            done_q, done_d;
  logic            last_ch;

  assign last_ch = (ch_q == chan_i);

  always_comb begin
    state_d      = state_q;
    ch_d         = ch_q;
    done_d       = done_q;
    load_trial_o = 1'b0;
    load_code_o  = 1'b0;
    step_o       = 1'b0;
    res_we_o     = 1'b0;
    flag_we_o    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (code_wr_i && cmp_en_i && is_single_i) begin
          load_code_o = 1'b1;
          ch_d        = chan_i;
          done_d      = 1'b0;
          state_d     = ST_CMP;
        end else if (start_i) begin
          load_trial_o = 1'b1;
          ch_d         = is_single_i ? chan_i : '0;
          done_d       = 1'b0;
          state_d      = ST_CONV;
        end
      end
      ST_CONV: begin
        if (stop_i) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          step_o = 1'b1;
          if (last_bit_i) state_d = ST_STORE;
        end
      end
      ST_STORE: begin
        if (stop_i) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          res_we_o = 1'b1;
          if (is_single_i || (is_oneshot_i && last_ch)) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            ch_d         = last_ch ? '0 : ch_q + 1'b1;
            load_trial_o = 1'b1;
            state_d      = ST_CONV;
          end
        end
      end
      ST_CMP: begin
        flag_we_o = 1'b1;
        done_d    = 1'b1;
        state_d   = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ch_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ch_q    <= ch_d;
      done_q  <= done_d;
    end
  end

  assign ch_o   = ch_q;
  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;

  // bit-cycle counter used only by the checks below
  logic [CNT_W-1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cyc_q <= '0;
    else if (load_trial_o)      cyc_q <= '0;
    else if (state_q == ST_CONV) cyc_q <= cyc_q + 1'b1;
  end

  // R4: store follows exactly BITS bit cycles
  a_r4_bit_cycles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STORE) |-> cyc_q == CNT_W'(BITS));

  // R5: scan steps to the next channel
  a_r5_scan_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STORE && !stop_i && !is_single_i && !last_ch)
      |=> (state_q == ST_CONV && ch_q == $past(ch_q) + 1'b1));

  // R6: continuous scan wraps to channel 0
  a_r6_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STORE && !stop_i && !is_single_i && !is_oneshot_i && last_ch)
      |=> (state_q == ST_CONV && ch_q == '0));

  // R7: stop aborts to idle with done set
  a_r7_stop_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_CONV || state_q == ST_STORE) && stop_i)
      |=> (state_q == ST_IDLE && done_q));

  // R8: compare lasts one cycle and sets done
  a_r8_cmp_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CMP) |=> (state_q == ST_IDLE && done_q));

  // R9: a running conversion keeps its channel regardless of writes
  a_r9_conv_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONV && !stop_i && !last_bit_i)
      |=> (state_q == ST_CONV && $stable(ch_q)));
endmodule

// File: rtl/sar_scan_ctrl.sv
module sar_scan_ctrl
  import sar_pkg::*;
#(
  parameter int unsigned CH     = 16,
  parameter int unsigned BITS   = 10,
  parameter int unsigned VIEW_W = 8,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned CH_W      = $clog2(CH),
  localparam int unsigned RES_BASE  = CH,
  localparam int unsigned VIEW_BASE = 2 * CH,
  localparam int unsigned ADDR_END  = 3 * CH,
  localparam int unsigned ADDR_W    = $clog2(ADDR_END)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              cmp_i,
  output logic [BITS-1:0]   dac_code_o,
  output logic [CH_W-1:0]   ch_sel_o
);
  logic [31:0] addr_w;
  assign addr_w = 32'(addr_i);

  logic ctrl_wr, code_wr, start, stop;
  assign ctrl_wr = wr_en_i && (addr_w == ADR_CTRL);
  assign code_wr = wr_en_i && (addr_w == ADR_CODE);
  assign start   = ctrl_wr && wdata_i[CTL_START_BIT];
  assign stop    = ctrl_wr && wdata_i[CTL_STOP_BIT];

  scan_mode_e      mode_q, mode_eff;
  logic            cmp_en_q, cmp_en_eff;
  logic [CH_W-1:0] chan_q, chan_eff;
  logic            busy, done, cfg_upd;

  // configuration only changes while idle; a start sees the fields it carries
  assign cfg_upd    = ctrl_wr && !busy;
  assign mode_eff   = cfg_upd ? scan_mode_e'(wdata_i[1:0]) : mode_q;
  assign cmp_en_eff = cfg_upd ? wdata_i[2] : cmp_en_q;
  assign chan_eff   = cfg_upd ? wdata_i[CTL_CH_LSB +: CH_W] : chan_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_SINGLE;
      cmp_en_q <= 1'b0;
      chan_q   <= '0;
    end else begin
      mode_q   <= mode_eff;
      cmp_en_q <= cmp_en_eff;
      chan_q   <= chan_eff;
    end
  end

  logic is_single, is_oneshot;
  assign is_single  = (mode_eff == MODE_SINGLE) || (mode_eff == MODE_RSVD);
  assign is_oneshot = (mode_eff == MODE_ONESHOT);

  logic            load_trial, load_code, step, last_bit, res_we, flag_we;
  logic [BITS-1:0] sar;
  logic [CH_W-1:0] ch;
  logic [BITS-1:0] rd_res;
  logic [CH-1:0]   flags;

  sar_sequencer #(.CH(CH), .BITS(BITS)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .stop_i       (stop),
    .code_wr_i    (code_wr),
    .is_single_i  (is_single),
    .is_oneshot_i (is_oneshot),
    .cmp_en_i     (cmp_en_eff),
    .chan_i       (chan_eff),
    .last_bit_i   (last_bit),
    .load_trial_o (load_trial),
    .load_code_o  (load_code),
    .step_o       (step),
    .res_we_o     (res_we),
    .flag_we_o    (flag_we),
    .ch_o         (ch),
    .busy_o       (busy),
    .done_o       (done)
  );

  sar_bit_engine #(.BITS(BITS)) u_eng (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_trial_i (load_trial),
    .load_code_i  (load_code),
    .code_i       (wdata_i[BITS-1:0]),
    .step_i       (step),
    .keep_i       (cmp_i),
    .sar_o        (sar),
    .last_o       (last_bit)
  );

  sar_result_bank #(.CH(CH), .BITS(BITS)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .res_we_i   (res_we),
    .res_ch_i   (ch),
    .res_data_i (sar),
    .flag_we_i  (flag_we),
    .flag_ch_i  (ch),
    .flag_i     (~cmp_i),
    .rd_ch_i    (addr_i[CH_W-1:0]),
    .rd_res_o   (rd_res),
    .flags_o    (flags)
  );

  assign dac_code_o = sar;
  assign ch_sel_o   = ch;

  always_comb begin
    rdata_o = '0;
    if (addr_w == ADR_CTRL) begin
      rdata_o[1:0]                 = mode_q;
      rdata_o[2]                   = cmp_en_q;
      rdata_o[4]                   = busy;
      rdata_o[5]                   = done;
      rdata_o[CTL_CH_LSB +: CH_W]  = chan_q;
    end else if (addr_w == ADR_CODE) begin
      rdata_o[BITS-1:0] = sar;
    end else if (addr_w == ADR_FLAG) begin
      rdata_o[CH-1:0] = flags;
    end else if (addr_w >= RES_BASE && addr_w < VIEW_BASE) begin
      rdata_o[BITS-1:0] = rd_res;
    end else if (addr_w >= VIEW_BASE && addr_w < ADDR_END) begin
      rdata_o[VIEW_W-1:0] = rd_res[BITS-1 -: VIEW_W];
    end
  end

  // R9: configuration fields hold while busy
  a_r9_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> ($stable(mode_q) && $stable(chan_q) && $stable(cmp_en_q)));
endmodule

// File: tb/sar_scan_ctrl_bench.sv
module sar_scan_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        cmp;
  logic [9:0]  dac;
  logic [3:0]  ch_sel;

  logic [10:0] vin [16];   // input in half-LSB units

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [11:0] level2(input logic [9:0] code);
    return (code == 10'd0) ? 12'd0 : ({2'b0, code} << 1) - 12'd1;
  endfunction

  function automatic logic [9:0] exp_code(input logic [10:0] v);
    int c;
    c = (int'(v) + 1) / 2;
    if (c > 1023) c = 1023;
    return 10'(c);
  endfunction

  assign cmp = ({1'b0, vin[ch_sel]} >= level2(dac));

  sar_scan_ctrl u_sar_scan_ctrl (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .wr_en_i    (wr_en),
    .addr_i     (addr),
    .wdata_i    (wdata),
    .rdata_o    (rdata),
    .cmp_i      (cmp),
    .dac_code_o (dac),
    .ch_sel_o   (ch_sel)
  );

  typedef struct {
    logic [5:0]  a;
    logic [15:0] e;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  function automatic logic [15:0] ctrl(input int mode, input bit cen, input bit st,
                                       input bit sp, input int chn);
    logic [15:0] w;
    w = '0;
    w[1:0] = 2'(mode);
    w[2] = cen;
    w[3] = st;
    w[6] = sp;
    w[11:8] = 4'(chn);
    return w;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdata;
    addr = '0;
    #1;
  endtask

  task automatic push(input logic [5:0] a, input logic [15:0] e, input string tag);
    exp_t it;
    it.a = a; it.e = e; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic push_res(input int c, input string tag);
    logic [9:0] r;
    r = exp_code(vin[c]);
    push(6'(16 + c), {6'b0, r}, tag);
    push(6'(32 + c), {8'b0, r[9:2]}, {tag, " view"});
  endtask

  // monitor side of the scoreboard: pop and compare against the design
  task automatic drain();
    logic [15:0] d;
    while (sb_q.size() > 0) begin
      exp_t it;
      it = sb_q.pop_front();
      rd(it.a, d);
      check(it.tag, d, it.e);
    end
  endtask

  task automatic wait_idle();
    logic [15:0] d;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      rd(6'd0, d);
      if (!d[4]) return;
    end
    check("wait_idle timeout", 16'h1, 16'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    for (int i = 0; i < 16; i++) vin[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(6'd0, d);  check("R1 ctrl after reset", d, 16'h0);
    rd(6'd2, d);  check("R1 flags after reset", d, 16'h0);
    rd(6'd21, d); check("R1 result ch5 after reset", d, 16'h0);

    // R4/R10 single conversion on channel 5
    vin[5] = 11'd700;
    wr(6'd0, ctrl(0, 0, 1, 0, 5));
    check("R10 first trial code", {6'b0, dac}, 16'h200);
    check("R4 channel select", {12'b0, ch_sel}, 16'd5);
    @(negedge clk);
    check("R10 second trial code", {6'b0, dac}, 16'h100);
    repeat (9) @(negedge clk);
    rd(6'd0, d); check("R4 busy during store cycle", {15'b0, d[4]}, 16'd1);
    @(negedge clk);
    rd(6'd0, d); check("R4 idle+done after 11 cycles", {14'b0, d[5:4]}, 16'b10);
    push_res(5, "R2 R3 single ch5");
    drain();

    // R5 one-pass scan over channels 0..4, edge inputs
    vin[0] = 11'd0; vin[1] = 11'd1; vin[2] = 11'd2047; vin[3] = 11'd1000; vin[4] = 11'd513;
    vin[6] = 11'd1500;
    wr(6'd0, ctrl(1, 0, 1, 0, 4));
    check("R5 scan begins at channel 0", {12'b0, ch_sel}, 16'd0);
    wait_idle();
    for (int c = 0; c < 5; c++) push_res(c, "R5 R2 scan result");
    push(6'd21, 16'd350, "R5 ch5 untouched by scan");
    push(6'd22, 16'd0, "R5 ch6 above last untouched");
    drain();

    // R6 continuous scan over 0..1
    vin[0] = 11'd40; vin[1] = 11'd60;
    wr(6'd0, ctrl(2, 0, 1, 0, 1));
    repeat (30) @(negedge clk);
    rd(6'd0, d); check("R6 still busy after a pass", {15'b0, d[4]}, 16'd1);
    vin[0] = 11'd300; vin[1] = 11'd900;
    repeat (50) @(negedge clk);
    rd(6'd0, d); check("R6 still busy after wrap", {15'b0, d[4]}, 16'd1);
    wr(6'd0, ctrl(2, 0, 0, 1, 1));
    rd(6'd0, d); check("R6 stop bit ends scan", {14'b0, d[5:4]}, 16'b10);
    push_res(0, "R6 ch0 follows input");
    push_res(1, "R6 ch1 follows input");
    drain();

    // R7 stop mid-conversion keeps old result
    vin[5] = 11'd100;
    wr(6'd0, ctrl(0, 0, 1, 0, 5));
    repeat (3) @(negedge clk);
    wr(6'd0, ctrl(0, 0, 0, 1, 5));
    rd(6'd0, d); check("R7 idle+done after stop", {14'b0, d[5:4]}, 16'b10);
    rd(6'd21, d); check("R7 ch5 not overwritten", d, 16'd350);

    // R9 start while busy ignored
    vin[6] = 11'd400; vin[7] = 11'd999;
    wr(6'd0, ctrl(0, 0, 1, 0, 6));
    repeat (2) @(negedge clk);
    wr(6'd0, ctrl(1, 0, 1, 0, 7));
    wait_idle();
    rd(6'd0, d); check("R9 config unchanged by busy write", {4'b0, d[11:8], 6'b0, d[1:0]}, 16'h0600);
    push_res(6, "R9 ch6 converted");
    push(6'd23, 16'd0, "R9 ch7 not started");
    drain();

    // R9 code write ignored without compare enable / in scan mode
    wr(6'd1, 16'd60);
    rd(6'd0, d); check("R9 code write ignored cmp off", {15'b0, d[4]}, 16'd0);
    wr(6'd0, ctrl(1, 1, 0, 0, 5));
    wr(6'd1, 16'd60);
    rd(6'd0, d); check("R9 code write ignored in scan", {15'b0, d[4]}, 16'd0);
    rd(6'd2, d); check("R9 flags untouched", d, 16'h0);

    // R8 compare mode
    wr(6'd0, ctrl(0, 1, 0, 0, 5));
    wr(6'd1, 16'd60);   // level 119 > 100
    rd(6'd0, d); check("R8 done cleared during compare", {14'b0, d[5:4]}, 16'b01);
    @(negedge clk);
    rd(6'd0, d); check("R8 done set after compare", {14'b0, d[5:4]}, 16'b10);
    rd(6'd2, d); check("R8 flag ch5 dac above input", d, 16'h0020);
    rd(6'd1, d); check("R8 code readback", d, 16'd60);
    wr(6'd1, 16'd50);   // level 99 < 100
    @(negedge clk);
    rd(6'd2, d); check("R8 flag ch5 input above dac", d, 16'h0000);
    wr(6'd1, 16'd0);    // level 0
    @(negedge clk);
    rd(6'd2, d); check("R8 flag code zero", d, 16'h0000);
    wr(6'd0, ctrl(0, 1, 0, 0, 3));
    wr(6'd1, 16'd501);  // level 1001 > 1000
    @(negedge clk);
    rd(6'd2, d); check("R8 flag ch3 set", d, 16'h0008);
    wr(6'd1, 16'd500);  // level 999 < 1000
    @(negedge clk);
    rd(6'd2, d); check("R8 flag ch3 cleared", d, 16'h0000);
    rd(6'd19, d); check("R8 compare leaves result", d, {6'b0, exp_code(11'd1000)});

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule